// File: doc/BRIEF.md
# Segment-Based Set-Associative Page Translator

This block turns a virtual page into a physical page frame. It does not walk a multi-level page table. Each virtual segment of 1024 pages is mapped onto a physical segment of 64 frames. Inside that physical segment the pages compete for frames the way cache lines compete for slots. A small directory outside the block has already chosen the physical segment. Its base arrives with each translation request. The block keeps a tag SRAM next to the page data array. For every frame the SRAM records which page of the virtual segment is resident. The block searches the selected set across all of its ways, as a set-associative cache does.

Each lookup takes two cycles: a tag read, then a compare. A hit returns the physical address and also writes the translation out to a TLB, so that later accesses avoid the search. A miss returns no address and raises a one-cycle page-fault pulse carrying the faulting virtual page number. After the fault has been serviced, a fill port installs the page. It uses an empty way if the set has one. Otherwise it replaces a way in per-set round-robin order. The fill reports the victim frame and the page that was evicted, so that a writeback can be scheduled.

Top module: `seg_xlate`

## Requirements
- R1: The virtual address fields are fixed: bits [14:0] are the 32 KB page offset, bits [24:15] are the page within the segment, and bits [32:25] are the virtual segment number. Within the page-in-segment field, bits [17:15] select the set and bits [24:18] form the stored 7-bit tag.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. Its result appears on resp_valid for exactly one cycle, right after the second edge following acceptance.
- R3: On a hit, resp_hit is 1 and resp_paddr = {frame, offset}. The frame is segment base × 64 + set × 8 + hit way, and the offset is copied from the request.
- R4: On a miss, resp_hit is 0 and resp_paddr is 0. fault_valid pulses for that one cycle, with fault_vpn equal to virtual address bits [32:15].
- R5: On a hit, tlb_wr is 1 in the same cycle as the response, with tlb_vpn = virtual address bits [32:15] and tlb_pfn equal to the hit frame. tlb_wr stays 0 on a miss.
- R6: A fill into a set that still has invalid ways writes the lowest-numbered invalid way. One cycle later fill_done is 1, fill_frame gives the frame written, and fill_evict is 0.
- R7: A fill into a full set replaces the way named by that set's round-robin pointer. Each pointer is 0 after reset and advances by one, wrapping at 8, only on such a replacement. fill_evict is 1, and fill_old_page gives the evicted page-in-segment number. A later lookup of the evicted page faults.
- R8: req_ready is 0 in a cycle where fill_valid is high and the fill targets the same segment base and set as req_seg and the set bits of req_vaddr. In every other cycle req_ready is 1.
- R9: After reset every way is invalid, so every lookup faults. All response, fault, TLB and fill outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | 33 | Virtual address |
| req_seg | input | 4 | Physical segment base from the directory |
| fill_valid | input | 1 | Install a page |
| fill_seg | input | 4 | Physical segment receiving the page |
| fill_page | input | 10 | Page-in-segment number being installed |
| fill_done | output | 1 | Fill report valid |
| fill_frame | output | 10 | Frame written by the fill |
| fill_evict | output | 1 | A valid page was replaced |
| fill_old_page | output | 10 | Page-in-segment number that was replaced |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Lookup found the page |
| resp_paddr | output | 25 | Physical address on a hit, zero on a miss |
| fault_valid | output | 1 | Page-fault pulse |
| fault_vpn | output | 18 | Faulting virtual page number |
| tlb_wr | output | 1 | Write translation into the TLB |
| tlb_vpn | output | 18 | Virtual page number for the TLB entry |
| tlb_pfn | output | 10 | Physical frame number for the TLB entry |

## Verification
Internal state shows at the ports in a known way. A lost or stuck valid bit turns into a wrong hit or a wrong fault on the next lookup of that set, two cycles after the request. A corrupted tag has the same effect. A round-robin pointer that drifts shows up on the next fill into a full set, one cycle later, as the wrong victim frame or the wrong evicted page. The bench keeps its own record of every set's contents and pointer. It compares each output on every clock, so the first divergence is reported in the cycle it appears.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int XLT_VSEG_W = 8;
  localparam int XLT_PIS_W  = 10;
  localparam int XLT_SET_W  = 3;
  localparam int XLT_WAYS   = 8;
  localparam int XLT_SEG_W  = 4;
  localparam int XLT_OFF_W  = 15;
endpackage

// File: rtl/xlt_tag_way.sv
// One way of the tag store: port A reads for lookups, port B writes fills
// and returns the entry it overwrote (read-first), both block-RAM friendly.
module xlt_tag_way #(
  parameter int AW = 7,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] old_data
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      old_data      <= mem[wr_addr];
      mem[wr_addr]  <= wr_data;
    end
  end
endmodule

// File: rtl/xlt_fill_ctrl.sv
// Valid bits and per-set round-robin pointers; picks the way a fill writes.
module xlt_fill_ctrl #(
  parameter int IDX_W = 7,
  parameter int WAYS  = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [WAYS-1:0]  lk_vld,
  output logic [WAY_W-1:0] fill_way,
  output logic             fill_full,
  output logic [WAYS-1:0]  fill_we
);
  localparam int NSETS = 2**IDX_W;

  logic [WAYS-1:0]  vld [NSETS];
  logic [WAY_W-1:0] rr  [NSETS];
  logic [WAYS-1:0]  cur;
  logic [WAY_W-1:0] free_way;

  assign cur       = vld[fill_idx];
  assign lk_vld    = vld[lk_idx];
  assign fill_full = &cur;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!cur[w]) free_way = WAY_W'(w);
    end
  end

  assign fill_way = fill_full ? rr[fill_idx] : free_way;

  always_comb begin
    fill_we = '0;
    if (fill_valid) fill_we[fill_way] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) begin
        vld[s] <= '0;
        rr[s]  <= '0;
      end
    end else if (fill_valid) begin
      vld[fill_idx][fill_way] <= 1'b1;
      if (fill_full) rr[fill_idx] <= rr[fill_idx] + 1'b1;
    end
  end
endmodule

// File: rtl/xlt_match.sv
// Tag compare across the ways of one set.
module xlt_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 7,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            key,
  output logic                        hit,
  output logic [WAY_W-1:0]            way
);
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[w] && tags[w] == key) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate import xlt_pkg::*; #(
  parameter int VSEG_W = XLT_VSEG_W,
  parameter int PIS_W  = XLT_PIS_W,
  parameter int SET_W  = XLT_SET_W,
  parameter int WAYS   = XLT_WAYS,
  parameter int SEG_W  = XLT_SEG_W,
  parameter int OFF_W  = XLT_OFF_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = PIS_W - SET_W,
  localparam int IDX_W = SEG_W + SET_W,
  localparam int VPN_W = VSEG_W + PIS_W,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PFN_W = SEG_W + SET_W + WAY_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              fill_valid,
  input  logic [SEG_W-1:0]  fill_seg,
  input  logic [PIS_W-1:0]  fill_page,
  output logic              fill_done,
  output logic [PFN_W-1:0]  fill_frame,
  output logic              fill_evict,
  output logic [PIS_W-1:0]  fill_old_page,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              fault_valid,
  output logic [VPN_W-1:0]  fault_vpn,
  output logic              tlb_wr,
  output logic [VPN_W-1:0]  tlb_vpn,
  output logic [PFN_W-1:0]  tlb_pfn
);
  // request and fill field split
  logic [SET_W-1:0] rq_set, fl_set;
  logic [TAG_W-1:0] fl_tag;
  logic [IDX_W-1:0] rq_idx, fl_idx;
  logic             accept;

  assign rq_set = req_vaddr[OFF_W +: SET_W];
  assign rq_idx = {req_seg, rq_set};
  assign fl_set = fill_page[SET_W-1:0];
  assign fl_tag = fill_page[PIS_W-1:SET_W];
  assign fl_idx = {fill_seg, fl_set};

  // a fill into the same set wins the cycle
  assign req_ready = !(fill_valid && fl_idx == rq_idx);
  assign accept    = req_valid && req_ready;

  logic [WAYS-1:0]             lk_vld, fl_we;
  logic [WAY_W-1:0]            fl_way;
  logic                        fl_full;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag, old_tag;

  xlt_fill_ctrl #(.IDX_W(IDX_W), .WAYS(WAYS)) u_fill (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_idx(fl_idx),
    .lk_idx(rq_idx), .lk_vld(lk_vld), .fill_way(fl_way),
    .fill_full(fl_full), .fill_we(fl_we)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    xlt_tag_way #(.AW(IDX_W), .DW(TAG_W)) u_ram (
      .clk(clk), .rd_en(accept), .rd_addr(rq_idx), .rd_data(rd_tag[w]),
      .wr_en(fl_we[w]), .wr_addr(fl_idx), .wr_data(fl_tag),
      .old_data(old_tag[w])
    );
  end

  // stage 1: tag read in flight
  logic              s1_v;
  logic [VA_W-1:0]   s1_vaddr;
  logic [SEG_W-1:0]  s1_seg;
  logic [WAYS-1:0]   s1_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_vaddr <= '0;
      s1_seg   <= '0;
      s1_vld   <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_vaddr <= req_vaddr;
        s1_seg   <= req_seg;
        s1_vld   <= lk_vld;
      end
    end
  end

  // stage 2: compare and register results
  logic              m_hit;
  logic [WAY_W-1:0]  m_way;
  logic [PFN_W-1:0]  m_pfn;

  xlt_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .vld(s1_vld), .tags(rd_tag),
    .key(s1_vaddr[OFF_W+SET_W +: TAG_W]), .hit(m_hit), .way(m_way)
  );

  assign m_pfn = {s1_seg, s1_vaddr[OFF_W +: SET_W], m_way};

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_paddr  <= '0;
      fault_valid <= 1'b0;
      fault_vpn   <= '0;
      tlb_wr      <= 1'b0;
      tlb_vpn     <= '0;
      tlb_pfn     <= '0;
    end else begin
      resp_valid  <= s1_v;
      resp_hit    <= s1_v && m_hit;
      resp_paddr  <= (s1_v && m_hit) ? {m_pfn, s1_vaddr[OFF_W-1:0]} : '0;
      fault_valid <= s1_v && !m_hit;
      fault_vpn   <= s1_vaddr[VA_W-1:OFF_W];
      tlb_wr      <= s1_v && m_hit;
      tlb_vpn     <= s1_vaddr[VA_W-1:OFF_W];
      tlb_pfn     <= m_pfn;
    end
  end

  // fill report
  logic [WAY_W-1:0] fw_q;
  logic [SET_W-1:0] fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_done  <= 1'b0;
      fill_frame <= '0;
      fill_evict <= 1'b0;
      fw_q       <= '0;
      fs_q       <= '0;
    end else begin
      fill_done  <= fill_valid;
      fill_frame <= {fill_seg, fl_set, fl_way};
      fill_evict <= fill_valid && fl_full;
      fw_q       <= fl_way;
      fs_q       <= fl_set;
    end
  end

  assign fill_old_page = fill_evict ? {old_tag[fw_q], fs_q} : '0;
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
  parameter int SEG_W = 4,
  parameter int SET_W = 3,
  parameter int OFF_W = 15,
  parameter int VA_W  = 33,
  parameter int PA_W  = 25,
  parameter int PFN_W = 10,
  parameter int PIS_W = 10,
  parameter int WAY_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [SEG_W-1:0] req_seg,
  input logic             fill_valid,
  input logic [SEG_W-1:0] fill_seg,
  input logic [PIS_W-1:0] fill_page,
  input logic             fill_done,
  input logic [PFN_W-1:0] fill_frame,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [PA_W-1:0]  resp_paddr,
  input logic             fault_valid,
  input logic             tlb_wr,
  input logic [PFN_W-1:0] tlb_pfn
);
  // R8: same-set fill blocks the request
  p_fill_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_seg == req_seg &&
     fill_page[SET_W-1:0] == req_vaddr[OFF_W +: SET_W]) |-> !req_ready);

  // R2: response two edges after acceptance
  p_resp_lat_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ##1 resp_valid);

  // R3: offset passes through on a hit
  p_offset_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ##1
      (!resp_hit || resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0], 2)));

  // R4: a fault is a miss response with no address
  p_fault_miss_r4: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (resp_valid && !resp_hit && resp_paddr == '0));

  // R5: TLB write accompanies every hit with the same frame
  p_tlb_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (tlb_wr && tlb_pfn == resp_paddr[PA_W-1:OFF_W]));

  p_tlb_only_hit_r5: assert property (@(posedge clk) disable iff (rst)
    tlb_wr |-> (resp_valid && resp_hit));

  // R6: fill reported next cycle in the addressed segment and set
  p_fill_rpt_r6: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (fill_done &&
      fill_frame[PFN_W-1:WAY_W] == {$past(fill_seg), $past(fill_page[SET_W-1:0])}));
endmodule

bind seg_xlate xlt_checker #(
  .SEG_W(SEG_W), .SET_W(SET_W), .OFF_W(OFF_W), .VA_W(VA_W),
  .PA_W(PA_W), .PFN_W(PFN_W), .PIS_W(PIS_W), .WAY_W(WAY_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_seg(req_seg), .fill_valid(fill_valid),
  .fill_seg(fill_seg), .fill_page(fill_page), .fill_done(fill_done),
  .fill_frame(fill_frame), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_paddr(resp_paddr), .fault_valid(fault_valid), .tlb_wr(tlb_wr),
  .tlb_pfn(tlb_pfn)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [32:0] req_vaddr = '0;
  logic [3:0]  req_seg = '0;
  logic        fill_valid = 1'b0;
  logic [3:0]  fill_seg = '0;
  logic [9:0]  fill_page = '0;
  logic        fill_done, fill_evict, resp_valid, resp_hit, fault_valid, tlb_wr;
  logic [9:0]  fill_frame, fill_old_page, tlb_pfn;
  logic [24:0] resp_paddr;
  logic [17:0] fault_vpn, tlb_vpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_seg(req_seg), .fill_valid(fill_valid),
    .fill_seg(fill_seg), .fill_page(fill_page), .fill_done(fill_done),
    .fill_frame(fill_frame), .fill_evict(fill_evict),
    .fill_old_page(fill_old_page), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_paddr(resp_paddr), .fault_valid(fault_valid),
    .fault_vpn(fault_vpn), .tlb_wr(tlb_wr), .tlb_vpn(tlb_vpn), .tlb_pfn(tlb_pfn)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference state: valid, tag, round-robin pointer per segment/set/way
  bit mv [16][8][8];
  int mt [16][8][8];
  int mrr [16][8];

  // pending lookup result (accepted last cycle, due after this edge)
  bit          pv = 0, ph = 0;
  logic [24:0] pa = '0;
  logic [17:0] pvpn = '0;
  logic [9:0]  ppfn = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit rv, input logic [32:0] va, input int rs,
                     input bit fv, input int fs, input int fp);
    bit acc, nh, ex_ev;
    logic [24:0] na;
    logic [9:0]  npfn, ex_frame, ex_old;
    int set, tag, w, fset, fway;
    @(negedge clk);
    req_valid = rv; req_vaddr = va; req_seg = 4'(rs);
    fill_valid = fv; fill_seg = 4'(fs); fill_page = 10'(fp);
    #1;
    // R8: fill to same segment and set blocks the request
    chk("R8 req_ready", 64'(req_ready),
        64'(!(fv && fs == rs && (fp % 8) == int'(va[17:15]))));
    acc = rv && req_ready;
    nh = 0; na = '0; npfn = '0;
    if (acc) begin
      set = int'(va[17:15]); tag = int'(va[24:18]);
      for (w = 0; w < 8; w++)
        if (!nh && mv[rs][set][w] && mt[rs][set][w] == tag) begin
          nh = 1;
          npfn = 10'(rs * 64 + set * 8 + w);
          na = {npfn, va[14:0]};
        end
    end
    ex_ev = 0; ex_frame = '0; ex_old = '0;
    if (fv) begin
      fset = fp % 8; fway = -1;
      for (w = 7; w >= 0; w--) if (!mv[fs][fset][w]) fway = w;
      if (fway < 0) begin
        fway = mrr[fs][fset];
        ex_ev = 1;
        ex_old = 10'(mt[fs][fset][fway] * 8 + fset);
        mrr[fs][fset] = (mrr[fs][fset] + 1) % 8;
      end
      ex_frame = 10'(fs * 64 + fset * 8 + fway);
      mv[fs][fset][fway] = 1;
      mt[fs][fset][fway] = fp / 8;
    end
    @(posedge clk);
    #1;
    chk("R2 resp_valid", 64'(resp_valid), 64'(pv));
    if (pv) begin
      chk("R3 resp_hit", 64'(resp_hit), 64'(ph));
      chk("R3 resp_paddr", 64'(resp_paddr), 64'(pa));
    end
    chk("R4 fault_valid", 64'(fault_valid), 64'(pv && !ph));
    if (pv && !ph) chk("R4 fault_vpn", 64'(fault_vpn), 64'(pvpn));
    chk("R5 tlb_wr", 64'(tlb_wr), 64'(pv && ph));
    if (pv && ph) begin
      chk("R5 tlb_vpn", 64'(tlb_vpn), 64'(pvpn));
      chk("R5 tlb_pfn", 64'(tlb_pfn), 64'(ppfn));
    end
    chk("R6 fill_done", 64'(fill_done), 64'(fv));
    if (fv) begin
      chk("R6 fill_frame", 64'(fill_frame), 64'(ex_frame));
      chk("R7 fill_evict", 64'(fill_evict), 64'(ex_ev));
      if (ex_ev) chk("R7 fill_old_page", 64'(fill_old_page), 64'(ex_old));
    end
    pv = acc; ph = nh; pa = na; pvpn = va[32:15]; ppfn = npfn;
  endtask

  function automatic logic [32:0] mkva(input int vseg, input int pis, input int off);
    return {8'(vseg), 10'(pis), 15'(off)};
  endfunction

  task automatic idle();
    cyc(0, '0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    bit dup;
    int fs2, fp2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R9: outputs idle after reset
    chk("R9 resp_valid", 64'(resp_valid), 0);
    chk("R9 fault_valid", 64'(fault_valid), 0);
    chk("R9 tlb_wr", 64'(tlb_wr), 0);
    chk("R9 fill_done", 64'(fill_done), 0);
    chk("R9 req_ready", 64'(req_ready), 1);

    // R9/R4: empty store faults
    cyc(1, mkva(3, 5, 16'h123), 3, 0, 0, 0);
    cyc(1, mkva(200, 1023, 32767), 15, 0, 0, 0);
    idle(); idle();

    // R6/R3/R5/R1: fills then hits in different sets
    cyc(0, '0, 0, 1, 3, 10'h2A);
    cyc(0, '0, 0, 1, 3, 10'h15);
    cyc(0, '0, 0, 1, 3, 10'h32);   // same set as 0x2A -> way 1
    cyc(1, mkva(7, 10'h2A, 15'h7ABC), 3, 0, 0, 0);
    cyc(1, mkva(9, 10'h32, 15'h0001), 3, 0, 0, 0);
    cyc(1, mkva(9, 10'h15, 15'h4000), 3, 0, 0, 0);
    cyc(1, mkva(9, 10'h15, 15'h4000), 2, 0, 0, 0); // other segment: miss
    idle(); idle();

    // R7: fill one set to capacity, then replace in round-robin order
    for (int t = 0; t < 10; t++) cyc(0, '0, 0, 1, 5, t * 8 + 2);
    cyc(1, mkva(1, 2, 5), 5, 0, 0, 0);        // evicted first: fault
    cyc(1, mkva(1, 10, 5), 5, 0, 0, 0);       // evicted second: fault
    cyc(1, mkva(1, 66, 5), 5, 0, 0, 0);       // replacement in way 0: hit
    cyc(1, mkva(1, 26, 5), 5, 0, 0, 0);       // untouched way 3: hit
    idle(); idle();

    // R8: same-set fill blocks; different set does not
    cyc(1, mkva(0, 3, 0), 6, 1, 6, 11);
    cyc(1, mkva(0, 3, 0), 6, 1, 6, 12);
    cyc(1, mkva(0, 11, 9), 6, 1, 7, 11);
    cyc(1, mkva(0, 11, 9), 6, 0, 0, 0);
    idle(); idle();

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      fs2 = $urandom % 4;
      fp2 = $urandom % 64;
      dup = 0;
      for (int w = 0; w < 8; w++)
        if (mv[fs2][fp2 % 8][w] && mt[fs2][fp2 % 8][w] == fp2 / 8) dup = 1;
      cyc(($urandom % 3) != 0, mkva($urandom % 256, $urandom % 64, $urandom % 32768),
          $urandom % 4, !dup && (($urandom % 10) < 3), fs2, fp2);
    end
    idle(); idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule